// File: doc/BRIEF.md
# Timestamped Input Recorder

This block sits on a trigger data input and keeps a copy of everything that arrives, together with the time at which each word arrived. The time is counted in clock cycles from the last accept for the buffer the word belongs to. Each buffer number has its own counter. So the stored record keeps both the latency of each event and the gaps between its words. Later, the same stream can be replayed with the same timing.

Each input word becomes a half-entry made of a time stamp and a data byte. Two half-entries that belong to the same event are packed into one wide memory write. The memory is a ring: when the write pointer passes the top, recording goes on over the oldest entries and a wrap flag is set. A freeze input stops recording. A host-side read port then returns the entries in order, oldest first, with the index counted from the oldest valid entry.

The input is a valid/ready stream, but the recorder never applies back-pressure. `in_ready` is held high, so a word is consumed in every cycle in which `in_valid` is high. While frozen, offered words are consumed and discarded.

Top module: `ts_recorder`

## Requirements
- R1: After reset, `rec_fill` is 0, `rec_wrapped` is 0, `drop_cnt` is 0 and `rd_valid` is 0.
- R2: A word's stamp is the number of clock cycles since the most recent accept for the word's own buffer number (`in_buf`). A word taken in the same cycle as that accept gets stamp 0.
- R3: A stamp stops at its maximum value (255 by default) and does not roll over.
- R4: An accept for one buffer number leaves the stamps of words tagged with other buffer numbers unchanged.
- R5: Entry layout: bits [35:34] hold the buffer number, bit 33 the first flag, bit 32 the single flag, bits [31:16] the newer half and bits [15:0] the older half. Each half is {stamp[7:0], data[7:0]}. A word that follows a held word of the same buffer, and is not a first word, is paired with it into one entry with single = 0.
- R6: A held word is written alone, with single = 1 and the upper half 0, in three cases: the next word carries a different buffer number, the next word is a first word, or freeze rises.
- R7: The first flag is 1 exactly when the older half is the first word taken for its buffer since that buffer's accept.
- R8: Each entry write advances the write pointer modulo 64. `rec_wrapped` sets when the pointer wraps and stays set. `rec_fill` counts entries up to a maximum of 64.
- R9: One cycle after `rd_req`, `rd_valid` is 1 and `rd_data` holds the entry at position `rd_idx`, where position 0 is the oldest valid entry.
- R10: While `freeze` is high, offered words are discarded: `rec_fill` does not change and `drop_cnt` increments once per offered word, stopping at its maximum.
- R11: `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Accept pulse |
| acc_buf | input | 2 | Buffer number of the accept |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input ready, always high |
| in_buf | input | 2 | Buffer number the input word belongs to |
| in_data | input | 8 | Input data byte |
| freeze | input | 1 | Stop recording while high |
| rd_req | input | 1 | Readback request |
| rd_idx | input | 6 | Readback position, counted from the oldest entry |
| rd_valid | output | 1 | Readback data valid |
| rd_data | output | 36 | Readback entry |
| rec_fill | output | 7 | Number of valid entries |
| rec_wrapped | output | 1 | Ring has wrapped |
| drop_cnt | output | 16 | Words discarded while frozen |

## Verification
Most internal faults in this block are visible only through readback, so the bench checks them after freeze. A stamp counter error shows up as a wrong stamp field. A pairing error shows up as a wrong single flag or as halves in the wrong place. A first-flag error shows up in bit 33. A pointer or wrap error, by contrast, shows at once: `rec_fill` and `rec_wrapped` change on the cycle after each write, and the bench compares them every cycle. If the oldest-entry base is wrong, readback comes out rotated, and this is seen from the first read index onward.

// File: rtl/ts_rec_pkg.sv
package ts_rec_pkg;
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_SINGLE = 2'd1,
    WR_PAIR   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/ts_rec_stamp.sv
module ts_rec_stamp #(
  parameter int NBUF = 4,
  parameter int TW   = 8,
  localparam int BW  = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [BW-1:0] acc_buf,
  input  logic [BW-1:0] sel_buf,
  input  logic          take,
  output logic [TW-1:0] stamp,
  output logic          first
);
  logic [NBUF-1:0][TW-1:0] cnt_all;
  logic [NBUF-1:0]         pend;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [TW-1:0] c;
    logic          p;
    logic          hit;
    assign hit = acc && (acc_buf == BW'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c <= '0;
        p <= 1'b0;
      end else begin
        if (hit)
          c <= TW'(1);
        else if (c != '1)
          c <= c + TW'(1);
        if (take && (sel_buf == BW'(b)))
          p <= 1'b0;
        else if (hit)
          p <= 1'b1;
      end
    end
    assign cnt_all[b] = c;
    assign pend[b]    = p;
  end

  logic same_hit;
  assign same_hit = acc && (acc_buf == sel_buf);
  assign stamp    = same_hit ? '0 : cnt_all[sel_buf];
  assign first    = same_hit || pend[sel_buf];
endmodule

// File: rtl/ts_rec_pack.sv
module ts_rec_pack
  import ts_rec_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8,
  parameter int BW = 2,
  localparam int HW = DW + TW,
  localparam int EW = 2 * HW + BW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word,
  input  logic [BW-1:0] wbuf,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] wstamp,
  input  logic          wfirst,
  input  logic          frz,
  output logic          wr_en,
  output logic [EW-1:0] wr_entry
);
  logic          have_lo, lo_first, frz_q;
  logic [BW-1:0] lo_buf;
  logic [HW-1:0] lo_half;
  logic [HW-1:0] new_half;
  logic          frz_rise, can_pair;
  wr_kind_e      kind;

  assign new_half = {wstamp, wdata};
  assign frz_rise = frz && !frz_q;
  assign can_pair = have_lo && (lo_buf == wbuf) && !wfirst;

  always_comb begin
    if (frz_rise && have_lo)      kind = WR_SINGLE;
    else if (word && can_pair)    kind = WR_PAIR;
    else if (word && have_lo)     kind = WR_SINGLE;
    else                          kind = WR_NONE;
  end

  always_comb begin
    wr_en = (kind != WR_NONE);
    if (kind == WR_PAIR)
      wr_entry = {lo_buf, lo_first, 1'b0, new_half, lo_half};
    else
      wr_entry = {lo_buf, lo_first, 1'b1, {HW{1'b0}}, lo_half};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_lo  <= 1'b0;
      lo_first <= 1'b0;
      lo_buf   <= '0;
      lo_half  <= '0;
      frz_q    <= 1'b0;
    end else begin
      frz_q <= frz;
      if (word && !can_pair) begin
        have_lo  <= 1'b1;
        lo_half  <= new_half;
        lo_buf   <= wbuf;
        lo_first <= wfirst;
      end else if (kind != WR_NONE) begin
        have_lo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ts_rec_ring.sv
module ts_rec_ring #(
  parameter int EW = 36,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_entry,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [EW-1:0] rd_data,
  output logic [AW:0]   fill,
  output logic          wrapped
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rd_addr;

  assign rd_addr = (wrapped ? wp : '0) + rd_idx;
  assign fill    = wrapped ? (AW+1)'(DEPTH) : {1'b0, wp};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      wrapped  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= mem[rd_addr];
      if (wr_en) begin
        wp <= wp + AW'(1);
        if (wp == '1) wrapped <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts_recorder.sv
module ts_recorder #(
  parameter int NBUF = 4,
  parameter int DW   = 8,
  parameter int TW   = 8,
  parameter int AW   = 6,
  parameter int DCW  = 16,
  localparam int BW  = $clog2(NBUF),
  localparam int EW  = 2 * (DW + TW) + BW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_vld,
  input  logic [BW-1:0]  acc_buf,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [BW-1:0]  in_buf,
  input  logic [DW-1:0]  in_data,
  input  logic           freeze,
  input  logic           rd_req,
  input  logic [AW-1:0]  rd_idx,
  output logic           rd_valid,
  output logic [EW-1:0]  rd_data,
  output logic [AW:0]    rec_fill,
  output logic           rec_wrapped,
  output logic [DCW-1:0] drop_cnt
);
  logic          word;
  logic [TW-1:0] stamp;
  logic          first;
  logic          wr_en;
  logic [EW-1:0] wr_entry;

  assign in_ready = 1'b1;
  assign word     = in_valid && !freeze;

  ts_rec_stamp #(.NBUF(NBUF), .TW(TW)) u_stamp (
    .clk(clk), .rst_n(rst_n), .acc(acc_vld), .acc_buf(acc_buf),
    .sel_buf(in_buf), .take(word), .stamp(stamp), .first(first)
  );

  ts_rec_pack #(.DW(DW), .TW(TW), .BW(BW)) u_pack (
    .clk(clk), .rst_n(rst_n), .word(word), .wbuf(in_buf), .wdata(in_data),
    .wstamp(stamp), .wfirst(first), .frz(freeze),
    .wr_en(wr_en), .wr_entry(wr_entry)
  );

  ts_rec_ring #(.EW(EW), .AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .fill(rec_fill), .wrapped(rec_wrapped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      drop_cnt <= '0;
    else if (in_valid && freeze && (drop_cnt != '1))
      drop_cnt <= drop_cnt + DCW'(1);
  end
endmodule

// File: rtl/ts_recorder_chk.sv
module ts_recorder_chk #(
  parameter int AW  = 6,
  parameter int DCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           freeze,
  input logic           rd_req,
  input logic           rd_valid,
  input logic [AW:0]    rec_fill,
  input logic           rec_wrapped,
  input logic [DCW-1:0] drop_cnt
);
  localparam int DEPTH = 1 << AW;

  // R8
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wrapped |=> rec_wrapped);
  // R8
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rec_fill == $past(rec_fill)) || (rec_fill == $past(rec_fill) + 1'b1));
  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_fill <= (AW+1)'(DEPTH));
  // R10
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> $stable(drop_cnt));
  // R10
  frozen_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && $past(freeze)) |=> $stable(rec_fill));
  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
endmodule

bind ts_recorder ts_recorder_chk #(.AW(AW), .DCW(DCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .rd_req(rd_req),
  .rd_valid(rd_valid), .rec_fill(rec_fill), .rec_wrapped(rec_wrapped),
  .drop_cnt(drop_cnt)
);

// File: tb/tb_ts_recorder.sv
module tb_ts_recorder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0;
  logic [1:0]  acc_buf = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_buf = '0;
  logic [7:0]  in_data = '0;
  logic        freeze = 1'b0;
  logic        rd_req = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic        rd_valid;
  logic [35:0] rd_data;
  logic [6:0]  rec_fill;
  logic        rec_wrapped;
  logic [15:0] drop_cnt;

  always #2 clk = ~clk;

  ts_recorder dut (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  // bench model, written from the requirements
  int          mcnt [4];
  bit          mpf [4];
  bit          m_have;
  logic [15:0] m_lo;
  int          m_lobuf;
  bit          m_lofirst;
  bit          m_frzq;
  logic [35:0] em [64];
  int          mwp = 0;
  bit          mwrap = 0;
  int          mdrop = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic void mwrite(input logic [35:0] e);
    em[mwp] = e;
    mwp = (mwp + 1) % 64;
    if (mwp == 0) mwrap = 1;
  endfunction

  task automatic step(input bit a, input int ab, input bit v, input int b,
                      input int d, input bit f);
    bit   word, hit, first, pair;
    int   st;
    logic [15:0] nh;
    acc_vld = a; acc_buf = 2'(ab); in_valid = v; in_buf = 2'(b);
    in_data = 8'(d); freeze = f;
    word  = v && !f;
    hit   = a && (ab == b);
    st    = hit ? 0 : mcnt[b];
    first = hit || mpf[b];
    nh    = {8'(st), 8'(d)};
    if (f && !m_frzq && m_have) begin
      mwrite({2'(m_lobuf), m_lofirst, 1'b1, 16'h0, m_lo});
      m_have = 0;
    end else if (word) begin
      pair = m_have && (m_lobuf == b) && !first;
      if (pair) begin
        mwrite({2'(m_lobuf), m_lofirst, 1'b0, nh, m_lo});
        m_have = 0;
      end else begin
        if (m_have) mwrite({2'(m_lobuf), m_lofirst, 1'b1, 16'h0, m_lo});
        m_have = 1; m_lo = nh; m_lobuf = b; m_lofirst = first;
      end
    end
    for (int k = 0; k < 4; k++) begin
      if (word && b == k) mpf[k] = 0;
      else if (a && ab == k) mpf[k] = 1;
      if (a && ab == k) mcnt[k] = 1;
      else if (mcnt[k] < 255) mcnt[k]++;
    end
    if (v && f && mdrop < 65535) mdrop++;
    m_frzq = f;
    @(posedge clk); #1;
    chk("R8 fill", 64'(rec_fill), 64'(mwrap ? 64 : mwp));
    chk("R8 wrapped", 64'(rec_wrapped), 64'(mwrap));
    chk("R10 drop", 64'(drop_cnt), 64'(mdrop));
    @(negedge clk);
  endtask

  task automatic rd(input int idx, output logic [35:0] q);
    rd_req = 1'b1; rd_idx = 6'(idx);
    @(posedge clk); #1;
    q = rd_data;
    chk("R9 rd_valid", 64'(rd_valid), 64'd1);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic readall();
    logic [35:0] q, e;
    int n, base;
    n = mwrap ? 64 : mwp;
    base = mwrap ? mwp : 0;
    for (int i = 0; i < n; i++) begin
      rd(i, q);
      e = em[(base + i) % 64];
      chk("R7 buf/first", 64'(q[35:33]), 64'(e[35:33]));
      chk("R6 single", 64'(q[32]), 64'(e[32]));
      chk("R2 stamps", 64'({q[31:24], q[15:8]}), 64'({e[31:24], e[15:8]}));
      chk("R5 R9 data order", 64'({q[23:16], q[7:0]}), 64'({e[23:16], e[7:0]}));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [35:0] q;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int k = 0; k < 4; k++) begin mcnt[k] = 0; mpf[k] = 0; end
    m_have = 0; m_frzq = 0; m_lo = '0; m_lobuf = 0; m_lofirst = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 R11 reset state
    chk("R1 fill", 64'(rec_fill), 64'd0);
    chk("R1 wrapped", 64'(rec_wrapped), 64'd0);
    chk("R1 drop", 64'(drop_cnt), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R11 ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: pair, flush on first word, saturation, buffer independence
    step(1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 8'h11, 0);
    step(0, 0, 1, 1, 8'h22, 0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 8'h33, 0);
    step(0, 0, 1, 2, 8'h44, 0);
    for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 2, 8'h55, 0);
    step(0, 0, 0, 0, 0, 1);
    rd(0, q);
    chk("R2 R5 R7 pair entry", 64'(q), 64'({2'd1, 1'b1, 1'b0, 8'd3, 8'h22, 8'd2, 8'h11}));
    rd(1, q);
    chk("R4 R6 single entry", 64'(q), 64'({2'd0, 1'b1, 1'b1, 16'h0, 8'd3, 8'h33}));
    rd(2, q);
    chk("R3 saturated stamp", 64'(q), 64'({2'd2, 1'b1, 1'b0, 8'd255, 8'h55, 8'd3, 8'h44}));
    readall();

    // random traffic with freeze bursts, enough to wrap the ring
    for (int i = 0; i < 900; i++) begin
      bit a, v, f;
      a = ($urandom % 8) == 0;
      v = ($urandom % 2) == 0;
      f = ($urandom % 40) == 0;
      step(a, int'($urandom % 4), v, int'($urandom % 4), int'($urandom % 256), f);
    end
    // R6 flush on freeze, R10 drops while frozen
    step(1, 3, 1, 3, 8'hA5, 0);
    step(0, 0, 1, 3, 8'h5A, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, i, 1);
    chk("R11 ready frozen", 64'(in_ready), 64'd1);
    chk("R8 wrapped after traffic", 64'(rec_wrapped), 64'd1);
    readall();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule